// File: doc/BRIEF.md
# Streaming Greyscale Gaussian Smoother

This block accepts a packetised colour pixel stream, one 24-bit beat per clock framed by start and end markers, and returns a smoothed greyscale stream with one pixel for every beat it accepts. Each beat is first reduced to an 8-bit grey level by averaging its three channels. The grey level then enters a chain of five row stores, each one image line long. The heads of these stores form a 5x5 window, which is weighted by an integer kernel and scaled back to 8 bits.

The window is taken along stream order. Tap (r, c) of the window for beat n holds the grey value of beat n - r*IMG_W - c. Because of this, the output for a beat is the smoothed value centred two lines and two pixels earlier, and the window wraps across line ends. A start-of-packet beat begins a fresh history. Taps that reach back past that beat read as zero.

Flow control is a single valid/ready pair on each side. The whole pipeline advances together whenever the output register is empty or is being drained. The image width and the pixel width are parameters. Another parameter chooses whether the weighted sum gets a register stage of its own.

Top module: `gb_stream_blur`

## Requirements
- R1: The grey level of a beat is floor((R + G + B) / 3), where R is in_rgb[23:16], G is in_rgb[15:8] and B is in_rgb[7:0].
- R2: For accepted beat n, out_pixel = floor(S / 159). S is the sum over r, c in 0..4 of w[r][c] * g(n - r*IMG_W - c). The kernel rows are [2 4 5 4 2], [4 9 12 9 4], [5 12 15 12 5], [4 9 12 9 4] and [2 4 5 4 2].
- R3: A tap that refers to a beat before the most recent accepted start-of-packet beat, or to any beat when no start-of-packet has been accepted since reset, contributes zero.
- R4: While out_ready is held high, in_ready stays high, so one beat is accepted and one pixel emitted per clock.
- R5: in_ready equals (!out_valid || out_ready). While out_valid is high and out_ready is low, out_valid, out_pixel, out_sop and out_eop hold their values.
- R6: out_sop and out_eop of an output pixel equal in_sop and in_eop of the beat that produced it.
- R7: During reset and directly after it, out_valid is low.
- R8: Every accepted beat yields exactly one output pixel, in order, and no pixel is emitted without an accepted beat.
- R9: With the default sum register stage and no backpressure, a beat accepted at clock edge k appears on out_valid right after edge k+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take a beat this cycle |
| in_rgb | input | 3*PIX_W | Colour beat: R high, G middle, B low |
| in_sop | input | 1 | Beat opens a packet |
| in_eop | input | 1 | Beat closes a packet |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Consumer takes the pixel |
| out_pixel | output | PIX_W | Smoothed grey level |
| out_sop | output | 1 | Pixel belongs to a packet-opening beat |
| out_eop | output | 1 | Pixel belongs to a packet-closing beat |

## Verification
The case that needs the most care is a start-of-packet beat arriving while the output is stalled. The new frame's history reset must wait until the held pixel drains, and the pixel still in flight must keep its old window. The bench produces this case by driving random gaps on in_valid together with random out_ready across back-to-back frames.

A behavioural model keeps the grey history since the last start marker and predicts each output. Each emitted pixel is compared with that prediction, including its flags. Every stalled cycle is also checked for held outputs.

// File: rtl/gb_pkg.sv
package gb_pkg;
   localparam int KDIM  = 5;
   localparam int KNORM = 159;

   // Symmetric integer kernel; folded to one quadrant.
   function automatic int unsigned gb_weight(input int r, input int c);
      int fr;
      int fc;
      int unsigned w;
      fr = (r > KDIM / 2) ? (KDIM - 1 - r) : r;
      fc = (c > KDIM / 2) ? (KDIM - 1 - c) : c;
      case (fr * 3 + fc)
         0:       w = 2;
         1:       w = 4;
         2:       w = 5;
         3:       w = 4;
         4:       w = 9;
         5:       w = 12;
         6:       w = 5;
         7:       w = 12;
         8:       w = 15;
         default: w = 0;
      endcase
      return w;
   endfunction

   function automatic int unsigned gb_weight_total();
      int unsigned t;
      t = 0;
      for (int r = 0; r < KDIM; r++)
         for (int c = 0; c < KDIM; c++)
            t += gb_weight(r, c);
      return t;
   endfunction
endpackage

// File: rtl/gb_grey.sv
module gb_grey #(
   parameter int PIX_W = 8
) (
   input  logic [3*PIX_W-1:0] rgb,
   output logic [PIX_W-1:0]   grey
);
   localparam int SUM_W = PIX_W + 2;

   logic [SUM_W-1:0] chan_sum;

   always_comb begin
      chan_sum = SUM_W'(rgb[3*PIX_W-1:2*PIX_W])
               + SUM_W'(rgb[2*PIX_W-1:PIX_W])
               + SUM_W'(rgb[PIX_W-1:0]);
      grey = PIX_W'(chan_sum / SUM_W'(3));
   end

   // R1: quotient is the truncated third of the channel sum
   always_comb begin
      assert_grey_trunc_R1: assert ((SUM_W'(grey) * SUM_W'(3) <= chan_sum)
                                  && (chan_sum - SUM_W'(grey) * SUM_W'(3) < SUM_W'(3)));
   end
endmodule

// File: rtl/gb_window.sv
module gb_window import gb_pkg::*; #(
   parameter int PIX_W = 8,
   parameter int IMG_W = 640
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              shift,
   input  logic                              sop,
   input  logic [PIX_W-1:0]                  grey,
   output logic [KDIM*KDIM-1:0][PIX_W-1:0]   win
);
   localparam int FILL_MAX = (KDIM - 1) * IMG_W + KDIM;
   localparam int FILL_W   = $clog2(FILL_MAX + 1);

   logic [FILL_W-1:0] fill_q;
   logic [PIX_W-1:0]  feed [KDIM];

   // Count of live history samples since the last start marker.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fill_q <= '0;
      end else if (shift) begin
         if (sop)
            fill_q <= FILL_W'(1);
         else if (fill_q != '0 && fill_q != FILL_W'(FILL_MAX))
            fill_q <= fill_q + 1'b1;
      end
   end

   assign feed[0] = grey;

   for (genvar r = 0; r < KDIM; r++) begin : g_row
      logic [PIX_W-1:0] cell_q [IMG_W];

      always_ff @(posedge clk) begin
         if (shift) begin
            cell_q[0] <= feed[r];
            for (int k = 1; k < IMG_W; k++)
               cell_q[k] <= cell_q[k-1];
         end
      end

      if (r < KDIM - 1) begin : g_link
         assign feed[r+1] = cell_q[IMG_W-1];
      end

      for (genvar c = 0; c < KDIM; c++) begin : g_col
         localparam logic [FILL_W-1:0] OFF = FILL_W'(r * IMG_W + c);
         assign win[r*KDIM+c] = (fill_q > OFF) ? cell_q[c] : '0;
      end
   end

   // R3: right after a start marker only the newest tap may be non-zero
   assert_sop_masks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (shift && sop) |=> (win[KDIM*KDIM-1:1] == '0));
endmodule

// File: rtl/gb_mac.sv
module gb_mac import gb_pkg::*; #(
   parameter int PIX_W     = 8,
   parameter bit SUM_STAGE = 1'b1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            adv,
   input  logic                            in_v,
   input  logic                            in_sop,
   input  logic                            in_eop,
   input  logic [KDIM*KDIM-1:0][PIX_W-1:0] win,
   output logic                            out_v,
   output logic                            out_sop,
   output logic                            out_eop,
   output logic [PIX_W-1:0]                out_pix
);
   localparam int SUM_W = PIX_W + $clog2(KNORM + 1);
   localparam logic [SUM_W-1:0] SUM_MAX = SUM_W'(KNORM * ((1 << PIX_W) - 1));

   typedef struct packed {
      logic             v;
      logic             sop;
      logic             eop;
      logic [SUM_W-1:0] sum;
   } stage_t;

   logic [SUM_W-1:0] acc;
   stage_t           s_d;
   stage_t           s_q;

   always_comb begin
      acc = '0;
      for (int r = 0; r < KDIM; r++)
         for (int c = 0; c < KDIM; c++)
            acc = acc + SUM_W'(gb_weight(r, c)) * SUM_W'(win[r*KDIM+c]);
   end

   assign s_d = '{v: in_v, sop: in_sop, eop: in_eop, sum: acc};

   if (SUM_STAGE) begin : g_sum_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            s_q <= '0;
         else if (adv)
            s_q <= s_d;
      end
   end else begin : g_sum_comb
      assign s_q = s_d;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_v   <= 1'b0;
         out_sop <= 1'b0;
         out_eop <= 1'b0;
         out_pix <= '0;
      end else if (adv) begin
         out_v   <= s_q.v;
         out_sop <= s_q.sop;
         out_eop <= s_q.eop;
         out_pix <= PIX_W'(s_q.sum / SUM_W'(KNORM));
      end
   end

   // R2: weighted sum never exceeds the kernel total times full scale
   assert_sum_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      s_q.v |-> (s_q.sum <= SUM_MAX));
endmodule

// File: rtl/gb_stream_blur.sv
module gb_stream_blur import gb_pkg::*; #(
   parameter int PIX_W     = 8,
   parameter int IMG_W     = 640,
   parameter bit SUM_STAGE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [3*PIX_W-1:0] in_rgb,
   input  logic               in_sop,
   input  logic               in_eop,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [PIX_W-1:0]   out_pixel,
   output logic               out_sop,
   output logic               out_eop
);
   if (IMG_W < KDIM) begin : g_chk_width
      $error("gb_stream_blur: IMG_W must be at least the kernel size");
   end
   if (PIX_W < 1) begin : g_chk_pix
      $error("gb_stream_blur: PIX_W must be positive");
   end
   if (gb_weight_total() != KNORM) begin : g_chk_kernel
      $error("gb_stream_blur: kernel weights do not match the normaliser");
   end

   logic                            adv;
   logic                            shift;
   logic [PIX_W-1:0]                grey;
   logic [KDIM*KDIM-1:0][PIX_W-1:0] win;
   logic                            v1_q;
   logic                            sop1_q;
   logic                            eop1_q;

   assign adv      = !out_valid || out_ready;
   assign in_ready = adv;
   assign shift    = adv && in_valid;

   gb_grey #(.PIX_W(PIX_W)) u_grey (
      .rgb  (in_rgb),
      .grey (grey)
   );

   gb_window #(.PIX_W(PIX_W), .IMG_W(IMG_W)) u_win (
      .clk   (clk),
      .rst_n (rst_n),
      .shift (shift),
      .sop   (in_sop),
      .grey  (grey),
      .win   (win)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v1_q   <= 1'b0;
         sop1_q <= 1'b0;
         eop1_q <= 1'b0;
      end else if (adv) begin
         v1_q   <= in_valid;
         sop1_q <= in_valid && in_sop;
         eop1_q <= in_valid && in_eop;
      end
   end

   gb_mac #(.PIX_W(PIX_W), .SUM_STAGE(SUM_STAGE)) u_mac (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (adv),
      .in_v    (v1_q),
      .in_sop  (sop1_q),
      .in_eop  (eop1_q),
      .win     (win),
      .out_v   (out_valid),
      .out_sop (out_sop),
      .out_eop (out_eop),
      .out_pix (out_pixel)
   );

   // R5: a stalled output keeps every field
   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_pixel)
                                     && $stable(out_sop) && $stable(out_eop)));

   // R5: no beat is taken while the output is blocked
   assert_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

   // R6: frame markers only travel with a valid pixel
   assert_flags_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_sop || out_eop) |-> out_valid);

   if (SUM_STAGE) begin : g_lat3
      // R9: three free-running edges carry a beat to the output
      assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_ready && out_ready) ##1 out_ready ##1 out_ready |=> out_valid);
   end else begin : g_lat2
      assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_ready && out_ready) ##1 out_ready |=> out_valid);
   end
endmodule

// File: tb/gb_stream_blur_bench.sv
module gb_stream_blur_bench;
   localparam int W    = 16;
   localparam int HMAX = 4 * W + 5;

   int kern [5][5] = '{'{2, 4, 5, 4, 2}, '{4, 9, 12, 9, 4}, '{5, 12, 15, 12, 5},
                       '{4, 9, 12, 9, 4}, '{2, 4, 5, 4, 2}};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [23:0] in_rgb = '0;
   logic        in_sop = 1'b0;
   logic        in_eop = 1'b0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [7:0]  out_pixel;
   logic        out_sop;
   logic        out_eop;

   always #5 clk = ~clk;

   gb_stream_blur #(.PIX_W(8), .IMG_W(W), .SUM_STAGE(1'b1)) u_gb_stream_blur (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_rgb(in_rgb), .in_sop(in_sop), .in_eop(in_eop), .out_valid(out_valid),
      .out_ready(out_ready), .out_pixel(out_pixel), .out_sop(out_sop), .out_eop(out_eop)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 0;

   int hist[$];
   int exp_pix[$];
   bit exp_sop[$];
   bit exp_eop[$];
   int got[$];
   bit seen_sop = 0;
   bit lat_mode = 0;
   bit rdy_rand = 0;
   bit d0 = 0, d1 = 0, d2 = 0;
   bit prev_stall = 0;
   int prev_pix = 0;
   bit prev_sop = 0, prev_eop = 0;
   bit last_acc = 0;

   task automatic check(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic model_accept();
      int g;
      int sum;
      g = (int'(in_rgb[23:16]) + int'(in_rgb[15:8]) + int'(in_rgb[7:0])) / 3;
      if (in_sop) begin
         hist.delete();
         seen_sop = 1;
      end
      if (seen_sop) begin
         hist.push_front(g);
         if (hist.size() > HMAX) void'(hist.pop_back());
      end
      sum = 0;
      for (int r = 0; r < 5; r++)
         for (int c = 0; c < 5; c++)
            if (r * W + c < hist.size()) sum += kern[r][c] * hist[r*W+c];
      exp_pix.push_back(sum / 159);
      exp_sop.push_back(in_sop);
      exp_eop.push_back(in_eop);
   endtask

   task automatic model_emit();
      int e;
      bit es, ee;
      if (exp_pix.size() == 0) begin
         check(0, "R8 output without accepted beat", out_pixel, -1);
      end else begin
         e  = exp_pix.pop_front();
         es = exp_sop.pop_front();
         ee = exp_eop.pop_front();
         check(out_pixel == e, "R2 smoothed pixel", out_pixel, e);
         check(out_sop == es && out_eop == ee, "R6 frame flags",
               int'({out_sop, out_eop}), int'({es, ee}));
      end
      got.push_back(out_pixel);
   endtask

   task automatic evaluate();
      bit acc, fire;
      acc  = in_valid && in_ready;
      fire = out_valid && out_ready;
      check(in_ready == (!out_valid || out_ready), "R5 ready rule", in_ready,
            int'(!out_valid || out_ready));
      if (prev_stall)
         check(out_valid === 1'b1 && out_pixel == prev_pix && out_sop == prev_sop
               && out_eop == prev_eop, "R5 held output", out_pixel, prev_pix);
      prev_stall = out_valid && !out_ready;
      prev_pix   = out_pixel;
      prev_sop   = out_sop;
      prev_eop   = out_eop;
      if (lat_mode) begin
         check(out_valid == d2, "R9 latency", out_valid, d2);
         check(in_ready == 1'b1, "R4 full rate", in_ready, 1);
         d2 = d1;
         d1 = d0;
         d0 = acc;
      end
      if (acc) model_accept();
      if (fire) model_emit();
      last_acc = acc;
   endtask

   task automatic step();
      out_ready = rdy_rand ? (($urandom % 10) < 7) : 1'b1;
      #1;
      evaluate();
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      in_valid = 0;
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic send(input logic [23:0] rgb, input bit sop, input bit eop, input bit gaps);
      if (gaps) begin
         in_valid = 0;
         while (($urandom % 4) == 0) step();
      end
      in_valid = 1;
      in_rgb   = rgb;
      in_sop   = sop;
      in_eop   = eop;
      do step(); while (!last_acc);
      in_valid = 0;
      in_sop   = 0;
      in_eop   = 0;
   endtask

   task automatic finish_run();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         finish_run();
      end
   end

   initial begin
      int base;
      int len;
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R7 out_valid in reset", out_valid, 0);
      rst_n = 1;
      #1;
      check(out_valid == 1'b0, "R7 out_valid after reset", out_valid, 0);
      @(negedge clk);
      lat_mode = 1;

      // beats before any start marker: all taps dead (R3)
      for (int i = 0; i < 3; i++) send({8'd90, 8'd90, 8'd90}, 0, 0, 0);
      // constant colour frame, grey = (200+100+31)/3 = 110 (R1)
      for (int i = 0; i < 6 * W; i++)
         send({8'd200, 8'd100, 8'd31}, i == 0, i == 6 * W - 1, 0);
      // white frame: first pixel has only the corner tap, 2*255/159 = 3 (R3)
      for (int i = 0; i < 2 * W; i++)
         send({8'd255, 8'd255, 8'd255}, i == 0, i == 2 * W - 1, 0);
      idle(6);
      lat_mode = 0;

      check(got.size() == 3 + 8 * W, "R8 one pixel per beat", got.size(), 3 + 8 * W);
      if (got.size() == 3 + 8 * W) begin
         for (int i = 0; i < 3; i++)
            check(got[i] == 0, "R3 no start marker yet", got[i], 0);
         base = 3 + 6 * W;
         check(got[base-1] == 110, "R1 channel average", got[base-1], 110);
         check(got[base] == 3, "R3 fresh frame history", got[base], 3);
      end

      // random traffic with gaps and backpressure
      rdy_rand = 1;
      for (int f = 0; f < 6; f++) begin
         len = 3 * W + int'($urandom % (3 * W));
         for (int i = 0; i < len; i++)
            send(24'($urandom), i == 0, i == len - 1, 1);
      end
      rdy_rand = 0;
      idle(10);
      check(exp_pix.size() == 0, "R8 every beat emitted", exp_pix.size(), 0);
      finish_run();
   end
endmodule